// File: doc/BRIEF.md
# Synthesizer Divider Chain and Output Mode Control

This block holds the digital half of a crystal-referenced clock synthesizer: the reference prescaler, the programmable feedback divider that closes the loop, the divide-by-two output stage and the logic that picks what drives the output. The oscillator of the loop is outside the block and arrives as the fast clock `vco_clk`. The crystal clock arrives as `ref_clk`. A single bidirectional test pin either carries the prescaled reference out or brings an external test clock in.

The 9-bit feedback divisor arrives on a parallel port. It follows the port while the active-low load strobe is low and is frozen when the strobe rises. A 2-bit mode input selects the output source. The two loop modes differ only in the spread-modulation request flag. In the reference self-test mode, the prescaled reference leaves on the test pin and the output runs at the reference divided by 32. In the bypass mode, an external clock on the test pin, halved, drives the output.

The mode is synchronized into both clock domains. A new mode only takes over while the output is low, so a high phase is never cut short. A lock-compare strobe marks the cycles where the feedback wrap and the prescaled reference edge coincide.

Top module: `clksyn_divchain`

## Requirements
- R1: The feedback strobe `fb_tick` pulses once every M cycles of `vco_clk`, where M is the 9-bit unsigned divisor (bit 8 weight 256, bit 0 weight 1). This holds at the valid range edges 190 and 510.
- R2: While `load_n` is low, the divisor in use follows `m_in` with no capture step.
- R3: On the rising edge of `load_n` the divisor is frozen. Later changes on `m_in` have no effect on the `fb_tick` period until `load_n` is low again.
- R4: While `mreset_n` is low, `fout` is 0 and `fout_n` is 1, `fb_tick`, `lock_hit` and `ssc_on` are 0, and the feedback counter is cleared. Asserting `mreset_n` forces `fout` low at once, without waiting for a clock.
- R5: In modes 2'b01 and 2'b11 (loop modes), `fout` toggles on every `vco_clk` edge, giving a period of two `vco_clk` cycles. `fout_n` is always the complement of `fout`.
- R6: `ssc_on` is 1 in mode 2'b01 and 0 in mode 2'b11. In every mode other than 2'b00, the block leaves `test_io` undriven.
- R7: In mode 2'b00, `test_io` is driven with `ref_clk` divided by 16 at 50% duty, and `fout` has a period of 32 `ref_clk` cycles.
- R8: In mode 2'b10, a clock applied to `test_io` drives `fout` at half its rate.
- R9: A new mode is adopted only while `fout` is low. A high phase that is under way when the mode input changes lasts its full length under the old source.
- R10: After reset, the feedback counter starts on the first prescaled reference edge. `lock_hit` pulses whenever a feedback wrap and a prescaled reference edge fall in the same `vco_clk` cycle. It does not pulse when M times the `vco_clk` period differs from the prescaled reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast loop clock, stand-in for the oscillator |
| ref_clk | input | 1 | Crystal reference clock |
| mreset_n | input | 1 | Master reset, active low, asserted asynchronously |
| load_n | input | 1 | Divisor load strobe, transparent low, captures on rise |
| m_in | input | 9 | Feedback divisor value |
| mode_in | input | 2 | Output source select |
| test_io | inout | 1 | Reference monitor out (2'b00) or external clock in (2'b10) |
| fout | output | 1 | Output clock, true side |
| fout_n | output | 1 | Output clock, complement side |
| ssc_on | output | 1 | Spread-modulation request, high in mode 2'b01 |
| fb_tick | output | 1 | One-cycle strobe at each feedback counter wrap |
| lock_hit | output | 1 | One-cycle strobe when feedback wrap meets reference edge |

## Verification
The bench uses the default parameters: a 9-bit divisor, a reference prescale of 16 and two synchronizer stages. It picks a reference period that makes the prescaled reference exactly 200 loop cycles long. With that choice, a divisor of 200 must produce a lock strobe on every reference edge and a divisor of 201 must produce none. The external test clock is five loop cycles long, so the bypass output period is exact. The self-test divide chain is visible at whole-nanosecond precision, which also makes the runt-free switch measurable as a full 1600-unit high phase.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  // Mode encodings are fixed by the pin decode.
  typedef enum logic [1:0] {
    MODE_SELFTEST = 2'b00,
    MODE_SPREAD   = 2'b01,
    MODE_EXTCLK   = 2'b10,
    MODE_PLAIN    = 2'b11
  } mode_e;

endpackage

// File: rtl/clksyn_sync.sv
module clksyn_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/clksyn_ref_div.sv
module clksyn_ref_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_req,
  output logic div_out,
  output logic test_oe
);

  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          div_q, div_d;
  logic          oe_q;

  always_comb begin
    cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + CW'(1);
    div_d = (cnt_d >= CW'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      oe_q  <= oe_req;
    end
  end

  assign div_out = div_q;
  assign test_oe = oe_q;

endmodule

// File: rtl/clksyn_m_path.sv
module clksyn_m_path #(
  parameter int M_W   = 9,
  parameter int M_RST = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_n,
  input  logic [M_W-1:0] m_in,
  input  logic           ref_rise,
  output logic [M_W-1:0] m_hold,
  output logic           fb_tick,
  output logic           lock_hit
);

  logic [M_W-1:0] hold_q, hold_d;
  logic [M_W-1:0] m_eff;
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           run_q, run_d;
  logic           fb_evt;
  logic           fb_q, lock_q;

  always_comb begin
    hold_d = load_n ? hold_q : m_in;
    m_eff  = load_n ? hold_q : m_in;
    fb_evt = run_q && (cnt_q == '0);
    run_d  = run_q | ref_rise;
    if (!run_q) begin
      cnt_d = ref_rise ? M_W'(1) : '0;
    end else if (cnt_q >= m_eff - M_W'(1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + M_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= M_W'(M_RST);
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fb_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      fb_q   <= fb_evt;
      lock_q <= fb_evt && ref_rise;
    end
  end

  assign m_hold   = hold_q;
  assign fb_tick  = fb_q;
  assign lock_hit = lock_q;

endmodule

// File: rtl/clksyn_out_stage.sv
module clksyn_out_stage
  import clksyn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       ref_rise,
  input  logic       ext_rise,
  output logic       fout,
  output mode_e      mode_act,
  output logic       ssc_on
);

  logic [1:0] req_prev_q;
  mode_e      act_q, act_d;
  logic       fout_q, fout_d;
  logic       tick;
  logic       adopt;

  always_comb begin
    case (act_q)
      MODE_SELFTEST: tick = ref_rise;
      MODE_EXTCLK:   tick = ext_rise;
      default:       tick = 1'b1;
    endcase
    adopt  = (mode_req == req_prev_q) && !fout_q && (mode_req != act_q);
    act_d  = adopt ? mode_e'(mode_req) : act_q;
    fout_d = fout_q ^ tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 2'b11;
      act_q      <= MODE_PLAIN;
      fout_q     <= 1'b0;
    end else begin
      req_prev_q <= mode_req;
      act_q      <= act_d;
      fout_q     <= fout_d;
    end
  end

  assign fout     = fout_q;
  assign mode_act = act_q;
  assign ssc_on   = (act_q == MODE_SPREAD);

endmodule

// File: rtl/clksyn_divchain.sv
module clksyn_divchain
  import clksyn_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int REF_DIV     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int M_RST       = 200
) (
  input  logic           vco_clk,
  input  logic           ref_clk,
  input  logic           mreset_n,
  input  logic           load_n,
  input  logic [M_W-1:0] m_in,
  input  logic [1:0]     mode_in,
  inout  wire            test_io,
  output logic           fout,
  output logic           fout_n,
  output logic           ssc_on,
  output logic           fb_tick,
  output logic           lock_hit
);

  logic           rst_vco_n, rst_ref_n;
  logic [1:0]     mode_vco, mode_ref;
  logic           ref16, test_oe, sel_test;
  logic           ref16_s, ext_s;
  logic           ref16_d, ext_d;
  logic           ref_rise, ext_rise;
  mode_e          mode_act;
  logic [M_W-1:0] m_hold;

  // Reset release, one synchronizer per domain
  clksyn_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_vco (
    .clk(vco_clk), .arst_n(mreset_n), .d(1'b1), .q(rst_vco_n));
  clksyn_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_ref (
    .clk(ref_clk), .arst_n(mreset_n), .d(1'b1), .q(rst_ref_n));

  // Mode into both domains
  clksyn_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_mode_vco (
    .clk(vco_clk), .arst_n(rst_vco_n), .d(mode_in), .q(mode_vco));
  clksyn_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_mode_ref (
    .clk(ref_clk), .arst_n(rst_ref_n), .d(mode_in), .q(mode_ref));

  assign sel_test = (mode_ref == MODE_SELFTEST);

  clksyn_ref_div #(.DIV(REF_DIV)) u_ref_div (
    .clk(ref_clk), .rst_n(rst_ref_n), .oe_req(sel_test),
    .div_out(ref16), .test_oe(test_oe));

  assign test_io = test_oe ? ref16 : 1'bz;

  // Prescaled reference and external clock into the loop domain
  clksyn_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_s (
    .clk(vco_clk), .arst_n(rst_vco_n), .d(ref16), .q(ref16_s));
  clksyn_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_s (
    .clk(vco_clk), .arst_n(rst_vco_n), .d(test_io), .q(ext_s));

  always_ff @(posedge vco_clk or negedge rst_vco_n) begin
    if (!rst_vco_n) begin
      ref16_d <= 1'b0;
      ext_d   <= 1'b0;
    end else begin
      ref16_d <= ref16_s;
      ext_d   <= ext_s;
    end
  end

  assign ref_rise = ref16_s && !ref16_d;
  assign ext_rise = ext_s && !ext_d;

  clksyn_m_path #(.M_W(M_W), .M_RST(M_RST)) u_m_path (
    .clk(vco_clk), .rst_n(rst_vco_n), .load_n(load_n), .m_in(m_in),
    .ref_rise(ref_rise), .m_hold(m_hold), .fb_tick(fb_tick),
    .lock_hit(lock_hit));

  clksyn_out_stage u_out (
    .clk(vco_clk), .rst_n(rst_vco_n), .mode_req(mode_vco),
    .ref_rise(ref_rise), .ext_rise(ext_rise), .fout(fout),
    .mode_act(mode_act), .ssc_on(ssc_on));

  assign fout_n = ~fout;

endmodule

// File: rtl/clksyn_divchain_chk.sv
module clksyn_divchain_chk #(
  parameter int M_W = 9
) (
  input logic           vco_clk,
  input logic           ref_clk,
  input logic           rst_vco_n,
  input logic           rst_ref_n,
  input logic           load_n,
  input logic           fout,
  input logic           fb_tick,
  input logic           lock_hit,
  input logic [1:0]     mode_act,
  input logic [1:0]     mode_ref,
  input logic           test_oe,
  input logic [M_W-1:0] m_hold
);

  AST_RESET_LOW: assert property (@(posedge vco_clk) !rst_vco_n |-> !fout); // R4

  AST_LOOP_RATE: assert property (@(posedge vco_clk) disable iff (!rst_vco_n)
    (mode_act == 2'b01 || mode_act == 2'b11) |=> (fout != $past(fout))); // R5

  AST_FB_SINGLE: assert property (@(posedge vco_clk) disable iff (!rst_vco_n)
    fb_tick |=> !fb_tick); // R1

  AST_LATCH_HOLD: assert property (@(posedge vco_clk) disable iff (!rst_vco_n)
    load_n |=> $stable(m_hold)); // R3

  AST_ADOPT_LOW: assert property (@(posedge vco_clk) disable iff (!rst_vco_n)
    (mode_act != $past(mode_act)) |-> !$past(fout)); // R9

  AST_LOCK_ON_WRAP: assert property (@(posedge vco_clk) disable iff (!rst_vco_n)
    lock_hit |-> fb_tick); // R10

  AST_PIN_RELEASED: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (mode_ref != 2'b00) |=> !test_oe); // R6

endmodule

bind clksyn_divchain clksyn_divchain_chk #(.M_W(M_W)) u_chk (
  .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_vco_n(rst_vco_n),
  .rst_ref_n(rst_ref_n), .load_n(load_n), .fout(fout), .fb_tick(fb_tick),
  .lock_hit(lock_hit), .mode_act(mode_act), .mode_ref(mode_ref),
  .test_oe(test_oe), .m_hold(m_hold));

// File: tb/clksyn_divchain_test.sv
module clksyn_divchain_test;

  logic       vco_clk, ref_clk, ext_clk;
  logic       mreset_n, load_n;
  logic [8:0] m_in;
  logic [1:0] mode_in;
  logic       drv_en, drv_ext, drv_val;
  wire        test_io;
  logic       fout, fout_n, ssc_on, fb_tick, lock_hit;
  int         n_tests = 0;
  int         n_fail  = 0;

  assign test_io = drv_en ? (drv_ext ? ext_clk : drv_val) : 1'bz;

  clksyn_divchain uut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .mreset_n(mreset_n),
    .load_n(load_n), .m_in(m_in), .mode_in(mode_in), .test_io(test_io),
    .fout(fout), .fout_n(fout_n), .ssc_on(ssc_on), .fb_tick(fb_tick),
    .lock_hit(lock_hit));

  // 125 MHz loop clock: 8 units per period
  initial begin vco_clk = 1'b0; forever #4 vco_clk = ~vco_clk; end
  initial begin ref_clk = 1'b0; #1; forever #50 ref_clk = ~ref_clk; end
  initial begin ext_clk = 1'b0; #2; forever #20 ext_clk = ~ext_clk; end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge vco_clk);
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? fout : test_io;
  endfunction

  task automatic next_rise(input int sel, output longint t);
    logic prev, cur;
    prev = pick(sel);
    forever begin
      @(negedge vco_clk);
      cur = pick(sel);
      if (!prev && cur) break;
      prev = cur;
    end
    t = longint'($time);
  endtask

  task automatic rise_period(input int sel, output longint per);
    longint t1, t2;
    next_rise(sel, t1);
    next_rise(sel, t2);
    per = t2 - t1;
  endtask

  task automatic fb_period(output int cyc);
    do @(negedge vco_clk); while (!fb_tick);
    do @(negedge vco_clk); while (!fb_tick);
    cyc = 0;
    do begin @(negedge vco_clk); cyc++; end while (!fb_tick);
  endtask

  task automatic set_mode(input logic [1:0] m, input int settle);
    @(negedge vco_clk);
    mode_in = m;
    cycles(settle);
  endtask

  task automatic t_reset;
    @(negedge vco_clk);
    check(fout == 1'b0, "R4", "fout in reset", fout, 0);
    check(fout_n == 1'b1, "R4", "fout_n in reset", fout_n, 1);
    check(fb_tick == 1'b0 && lock_hit == 1'b0, "R4", "strobes in reset",
          {fb_tick, lock_hit}, 0);
    check(ssc_on == 1'b0, "R4", "ssc_on in reset", ssc_on, 0);
    mreset_n = 1'b1;
    cycles(20);
  endtask

  task automatic t_loop_modes;
    longint per;
    set_mode(2'b11, 10);
    rise_period(0, per);
    check(per == 16, "R5", "fout period mode 11", per, 16);
    check(fout_n == ~fout, "R5", "fout_n complement", fout_n, ~fout);
    check(ssc_on == 1'b0, "R6", "ssc_on mode 11", ssc_on, 0);
    drv_en = 1'b1; drv_ext = 1'b0; drv_val = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cycles(110);
      check(test_io === 1'b1, "R6", "pin released mode 11 high", test_io, 1);
    end
    drv_val = 1'b0;
    cycles(110);
    check(test_io === 1'b0, "R6", "pin released mode 11 low", test_io, 0);
    drv_en = 1'b0;
    set_mode(2'b01, 10);
    check(ssc_on == 1'b1, "R6", "ssc_on mode 01", ssc_on, 1);
    rise_period(0, per);
    check(per == 16, "R5", "fout period mode 01", per, 16);
    drv_en = 1'b1; drv_val = 1'b1;
    cycles(110);
    check(test_io === 1'b1, "R6", "pin released mode 01", test_io, 1);
    drv_en = 1'b0;
    set_mode(2'b11, 10);
  endtask

  task automatic t_divisor;
    int cyc;
    load_n = 1'b0;
    m_in = 9'd190; fb_period(cyc);
    check(cyc == 190, "R1", "period M=190", cyc, 190);
    m_in = 9'd510; fb_period(cyc);
    check(cyc == 510, "R1", "period M=510", cyc, 510);
    m_in = 9'h155; fb_period(cyc);
    check(cyc == 341, "R1", "period M=0x155", cyc, 341);
    m_in = 9'd220; fb_period(cyc);
    check(cyc == 220, "R2", "transparent M=220", cyc, 220);
    @(negedge vco_clk); load_n = 1'b1;
    cycles(5);
    m_in = 9'd300; fb_period(cyc);
    check(cyc == 220, "R3", "held after strobe rise", cyc, 220);
    @(negedge vco_clk); load_n = 1'b0;
    fb_period(cyc);
    check(cyc == 300, "R2", "follows after strobe low", cyc, 300);
  endtask

  task automatic t_lock;
    int hits;
    load_n = 1'b0; m_in = 9'd200;
    cycles(4);
    mreset_n = 1'b0;
    #1;
    check(fout == 1'b0, "R4", "fout forced low at reset", fout, 0);
    cycles(3);
    check(fb_tick == 1'b0, "R4", "fb_tick idle in reset", fb_tick, 0);
    mreset_n = 1'b1;
    cycles(800);
    hits = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge vco_clk); if (lock_hit) hits++; end
    check(hits == 5, "R10", "lock hits M=200", hits, 5);
    m_in = 9'd201;
    cycles(300);
    hits = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge vco_clk); if (lock_hit) hits++; end
    check(hits == 0, "R10", "lock hits M=201", hits, 0);
    m_in = 9'd200;
  endtask

  task automatic t_selftest;
    longint per;
    drv_en = 1'b0;
    set_mode(2'b00, 600);
    rise_period(1, per);
    check(per == 1600, "R7", "test_io period", per, 1600);
    rise_period(0, per);
    check(per == 3200, "R7", "fout period mode 00", per, 3200);
  endtask

  task automatic t_switch;
    longint tr, tf, per;
    next_rise(0, tr);
    mode_in = 2'b11;
    do @(negedge vco_clk); while (fout);
    tf = longint'($time);
    check(tf - tr == 1600, "R9", "high phase kept on switch", tf - tr, 1600);
    cycles(10);
    rise_period(0, per);
    check(per == 16, "R9", "loop rate after switch", per, 16);
  endtask

  task automatic t_extclk;
    longint per;
    cycles(150);
    set_mode(2'b10, 10);
    drv_en = 1'b1; drv_ext = 1'b1;
    cycles(40);
    rise_period(0, per);
    check(per == 80, "R8", "fout period mode 10", per, 80);
    check(ssc_on == 1'b0, "R6", "ssc_on mode 10", ssc_on, 0);
    set_mode(2'b11, 20);
    drv_en = 1'b0;
  endtask

  initial begin
    mreset_n = 1'b1;
    load_n   = 1'b0;
    m_in     = 9'd200;
    mode_in  = 2'b11;
    drv_en   = 1'b0;
    drv_ext  = 1'b0;
    drv_val  = 1'b0;
    #1 mreset_n = 1'b0;
    cycles(5);
    t_reset();
    t_loop_modes();
    t_divisor();
    t_lock();
    t_selftest();
    t_switch();
    t_extclk();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule